// File: doc/BRIEF.md
# Indirect SERDES Control-Register Access Engine

This engine accepts one read or write request at a time for a 16-bit SERDES control-register address. It carries the request out through a paged memory-mapped window. A window register holds the page, and the page holds a device number plus the upper address bits. Each register touch is therefore a pair of bus accesses. First the page is written to window offset 0x800. Then the word offset of the register inside the window is accessed. The bus is locked across the pair, so no other master can slip in between the two accesses.

On top of the window, every control-register transaction follows the SERDES handshake. The engine first polls a busy flag until it reads clear. It then loads the target address, loads the data for a write, and sets the start bit. A read polls busy a second time and then fetches the data word. Fixed gaps, set as cycle counts by parameters, separate the steps. A poll limit turns a busy flag that never clears into an error response, so the engine does not hang. The requester sees a one-cycle acknowledge. For a read, the data and the error flag are valid in that same cycle.

Top module: `serdes_cr_engine`

## Requirements
- R1: Every register access begins with a bus write to window offset 0x800. Its data is ((device & 0x1f) << 7) | ((address >> 9) & 0x7f), so that bits [11:7] hold the device and bits [6:0] hold the upper address bits.
- R2: The access right after a page write goes to window offset (address & 0x1ff) << 2. The lock output is high from the page write through that access. A pending access keeps its address, direction and data stable until it is accepted.
- R3: Each transaction starts by reading the control register (0x80a0) until bit 0 (busy) reads 0. Consecutive busy reads are at least POLL_GAP_CYC cycles apart.
- R4: A write transaction, once busy is clear, writes the address register (0x80a1) with the target address. It then writes the data register (0x80a2) with the write data. It then writes the control register with 0x0003 (bit 0 start, bit 1 write).
- R5: A read transaction, once busy is clear, writes the address register, then writes the control register with 0x0001. It polls busy again, then reads the data register and returns that word on req_rdata.
- R6: At least ADDR_GAP_CYC cycles pass between the end of an address-register, data-register or start write and the next page write.
- R7: If POLL_LIMIT busy reads in a row all return busy, the engine ends the request with req_err=1 and req_rdata=0. It makes no further bus access for that request.
- R8: req_ack is high for exactly one cycle per request, with the lock output low. req_err is 0 on success.
- R9: req_valid is taken only while idle. A request raised during a transaction starts no bus access and produces no acknowledge.
- R10: During reset, bus_valid, bus_lock and req_ack are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_write | input | 1 | 1 = write transaction, 0 = read |
| req_addr | input | 16 | SERDES control-register address |
| req_wdata | input | DATA_W | Write data |
| req_dev | input | 5 | Device number placed in the page |
| req_ack | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Poll limit reached, valid with req_ack |
| req_rdata | output | DATA_W | Read data, valid with req_ack |
| bus_valid | output | 1 | Window access pending |
| bus_write | output | 1 | Window access direction |
| bus_addr | output | 12 | Byte offset inside the window |
| bus_wdata | output | DATA_W | Window write data |
| bus_ready | input | 1 | Window access accepted this cycle |
| bus_rdata | input | DATA_W | Window read data, valid with bus_ready |
| bus_lock | output | 1 | Holds the bus across a page/offset pair |

## Verification
The assertions check the window framing on every cycle. A rising lock must start with a page write. An accepted page write must be followed by a non-page access. A stalled access must hold steady. A pending access must be locked. They also check that the acknowledge is a single pulse outside any lock, and that an error carries zero data. Only the bench scenarios can show the rest, because they decode each page and offset pair back into a register address. Those scenarios cover the correctness of the page and offset arithmetic, the order of register steps for reads and writes, the measured gap lengths, the returned data, the poll-limit cut-off, and the fact that a request raised mid-transaction has no effect.

// File: rtl/serdes_cr_pkg.sv
package serdes_cr_pkg;

    localparam logic [15:0] CR_CTRL_REG = 16'h80a0;
    localparam logic [15:0] CR_ADDR_REG = 16'h80a1;
    localparam logic [15:0] CR_DATA_REG = 16'h80a2;

    localparam int          WIN_AW   = 12;
    localparam int          DEV_W    = 5;
    localparam logic [11:0] PAGE_OFS = 12'h800;

    typedef enum logic [1:0] {
        WN_IDLE,
        WN_PAGE,
        WN_ACC
    } win_st_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_POLL,
        SQ_POLL_GAP,
        SQ_ADDR,
        SQ_ADDR_GAP,
        SQ_DATA,
        SQ_DATA_GAP,
        SQ_START,
        SQ_START_GAP,
        SQ_FETCH
    } seq_st_e;

endpackage

// File: rtl/cr_gap_timer.sv
module cr_gap_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/cr_window.sv
module cr_window
    import serdes_cr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr,
    input  logic [15:0]       reg_addr,
    input  logic [DEV_W-1:0]  dev_id,
    input  logic [DATA_W-1:0] wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [WIN_AW-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_lock
);
    typedef struct packed {
        win_st_e           st;
        logic              wr;
        logic [15:0]       addr;
        logic [DEV_W-1:0]  dev;
        logic [DATA_W-1:0] wdata;
    } win_state_t;

    win_state_t r_d, r_q;
    logic [11:0] page_val;

    assign page_val = {r_q.dev, r_q.addr[15:9]};

    always_comb begin
        r_d       = r_q;
        done      = 1'b0;
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (r_q.st)
            WN_IDLE: begin
                if (start) begin
                    r_d.st    = WN_PAGE;
                    r_d.wr    = wr;
                    r_d.addr  = reg_addr;
                    r_d.dev   = dev_id;
                    r_d.wdata = wdata;
                end
            end
            WN_PAGE: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = PAGE_OFS;
                bus_wdata = DATA_W'(page_val);
                if (bus_ready) r_d.st = WN_ACC;
            end
            WN_ACC: begin
                bus_valid = 1'b1;
                bus_write = r_q.wr;
                bus_addr  = {1'b0, r_q.addr[8:0], 2'b00};
                bus_wdata = r_q.wdata;
                if (bus_ready) begin
                    done   = 1'b1;
                    r_d.st = WN_IDLE;
                end
            end
            default: r_d.st = WN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: WN_IDLE, wr: 1'b0, addr: '0, dev: '0, wdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata    = bus_rdata;
    assign bus_lock = (r_q.st != WN_IDLE);
endmodule

// File: rtl/serdes_cr_engine.sv
module serdes_cr_engine
    import serdes_cr_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int ADDR_GAP_CYC = 3125,
    parameter int POLL_GAP_CYC = 625,
    parameter int POLL_LIMIT   = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [15:0]       req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [4:0]        req_dev,
    output logic              req_ack,
    output logic              req_err,
    output logic [DATA_W-1:0] req_rdata,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [11:0]       bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_lock
);
    localparam int MAX_GAP = (ADDR_GAP_CYC > POLL_GAP_CYC) ? ADDR_GAP_CYC : POLL_GAP_CYC;
    localparam int TW      = (MAX_GAP < 1) ? 1 : $clog2(MAX_GAP + 1);
    localparam int PW      = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        seq_st_e           st;
        logic              second;
        logic              issued;
        logic              wr;
        logic [15:0]       addr;
        logic [DEV_W-1:0]  dev;
        logic [DATA_W-1:0] wdata;
        logic [PW-1:0]     poll_cnt;
        logic              ack;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } seq_state_t;

    seq_state_t r_d, r_q;

    logic              win_start, win_wr, win_done;
    logic [15:0]       win_addr;
    logic [DATA_W-1:0] win_wdata, win_rdata;
    logic              tmr_load, tmr_zero;
    logic [TW-1:0]     tmr_val;
    logic              issue_st;

    always_comb begin
        r_d       = r_q;
        r_d.ack   = 1'b0;
        win_wr    = 1'b0;
        win_addr  = CR_CTRL_REG;
        win_wdata = '0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        issue_st  = 1'b0;

        unique case (r_q.st)
            SQ_POLL:  begin issue_st = 1'b1; end
            SQ_ADDR:  begin issue_st = 1'b1; win_wr = 1'b1; win_addr = CR_ADDR_REG; win_wdata = DATA_W'(r_q.addr); end
            SQ_DATA:  begin issue_st = 1'b1; win_wr = 1'b1; win_addr = CR_DATA_REG; win_wdata = r_q.wdata; end
            SQ_START: begin issue_st = 1'b1; win_wr = 1'b1; win_wdata = r_q.wr ? DATA_W'(3) : DATA_W'(1); end
            SQ_FETCH: begin issue_st = 1'b1; win_addr = CR_DATA_REG; end
            default: ;
        endcase

        win_start = issue_st && !r_q.issued;
        if (win_start) r_d.issued = 1'b1;
        if (win_done)  r_d.issued = 1'b0;

        unique case (r_q.st)
            SQ_IDLE: begin
                if (req_valid) begin
                    r_d.st       = SQ_POLL;
                    r_d.second   = 1'b0;
                    r_d.wr       = req_write;
                    r_d.addr     = req_addr;
                    r_d.dev      = req_dev;
                    r_d.wdata    = req_wdata;
                    r_d.poll_cnt = '0;
                end
            end
            SQ_POLL: begin
                if (win_done) begin
                    if (!win_rdata[0]) begin
                        r_d.poll_cnt = '0;
                        r_d.st       = r_q.second ? SQ_FETCH : SQ_ADDR;
                    end else if (r_q.poll_cnt == PW'(POLL_LIMIT - 1)) begin
                        r_d.st    = SQ_IDLE;
                        r_d.ack   = 1'b1;
                        r_d.err   = 1'b1;
                        r_d.rdata = '0;
                    end else begin
                        r_d.poll_cnt = r_q.poll_cnt + 1'b1;
                        r_d.st       = SQ_POLL_GAP;
                        tmr_load     = 1'b1;
                        tmr_val      = TW'(POLL_GAP_CYC);
                    end
                end
            end
            SQ_POLL_GAP: if (tmr_zero) r_d.st = SQ_POLL;
            SQ_ADDR: begin
                if (win_done) begin
                    r_d.st   = SQ_ADDR_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(ADDR_GAP_CYC);
                end
            end
            SQ_ADDR_GAP: if (tmr_zero) r_d.st = r_q.wr ? SQ_DATA : SQ_START;
            SQ_DATA: begin
                if (win_done) begin
                    r_d.st   = SQ_DATA_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(ADDR_GAP_CYC);
                end
            end
            SQ_DATA_GAP: if (tmr_zero) r_d.st = SQ_START;
            SQ_START: begin
                if (win_done) begin
                    if (r_q.wr) begin
                        r_d.st    = SQ_IDLE;
                        r_d.ack   = 1'b1;
                        r_d.err   = 1'b0;
                        r_d.rdata = '0;
                    end else begin
                        r_d.st   = SQ_START_GAP;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(ADDR_GAP_CYC);
                    end
                end
            end
            SQ_START_GAP: begin
                if (tmr_zero) begin
                    r_d.st     = SQ_POLL;
                    r_d.second = 1'b1;
                end
            end
            SQ_FETCH: begin
                if (win_done) begin
                    r_d.st    = SQ_IDLE;
                    r_d.ack   = 1'b1;
                    r_d.err   = 1'b0;
                    r_d.rdata = win_rdata;
                end
            end
            default: r_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: SQ_IDLE, second: 1'b0, issued: 1'b0, wr: 1'b0, addr: '0,
                     dev: '0, wdata: '0, poll_cnt: '0, ack: 1'b0, err: 1'b0, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    cr_window #(.DATA_W(DATA_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (win_start),
        .wr        (win_wr),
        .reg_addr  (win_addr),
        .dev_id    (r_q.dev),
        .wdata     (win_wdata),
        .done      (win_done),
        .rdata     (win_rdata),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata),
        .bus_lock  (bus_lock)
    );

    cr_gap_timer #(.CNT_W(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign req_ack   = r_q.ack;
    assign req_err   = r_q.err;
    assign req_rdata = r_q.rdata;
endmodule

// File: rtl/serdes_cr_engine_chk.sv
module serdes_cr_engine_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ack,
    input logic              req_err,
    input logic [DATA_W-1:0] req_rdata,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic              bus_write,
    input logic [11:0]       bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_lock
);
    // R1
    page_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_lock) |-> (bus_valid && bus_write && bus_addr == 12'h800));

    // R2
    locked_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> bus_lock);

    // R2
    offset_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && bus_write && bus_addr == 12'h800)
        |=> (bus_valid && bus_lock && bus_addr != 12'h800));

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready)
        |=> (bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));

    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    // R8
    ack_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> !bus_lock);

    // R7
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ack && req_err) |-> (req_rdata == '0));
endmodule

bind serdes_cr_engine serdes_cr_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ack   (req_ack),
    .req_err   (req_err),
    .req_rdata (req_rdata),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_lock  (bus_lock)
);

// File: tb/tb_serdes_cr_engine.sv
module tb_serdes_cr_engine;
    localparam int DW   = 16;
    localparam int AGAP = 6;
    localparam int PGAP = 3;
    localparam int PLIM = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [15:0]   req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [4:0]    req_dev = '0;
    logic          req_ack, req_err;
    logic [DW-1:0] req_rdata;
    logic          bus_valid, bus_write, bus_lock;
    logic [11:0]   bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ready = 1'b0;
    logic [DW-1:0] bus_rdata = '0;

    always #4 clk = ~clk;

    serdes_cr_engine #(.DATA_W(DW), .ADDR_GAP_CYC(AGAP), .POLL_GAP_CYC(PGAP), .POLL_LIMIT(PLIM)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_dev(req_dev),
        .req_ack(req_ack), .req_err(req_err), .req_rdata(req_rdata),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .bus_lock(bus_lock));

    int n_chk = 0, n_fail = 0, cyc = 0;

    // window/SERDES model state
    int          busy_cfg = 0, txn_id = 0, seen_id = 0, busy_left = 0, hs_n = 0, wcnt = 0;
    int          hs_total = 0, log_n = 0, page_cyc = 0;
    logic [4:0]  exp_dev = '0;
    logic [11:0] page = '0;
    bit          page_fresh = 0;
    logic [15:0] areg = '0, dreg = '0, wr_seen_a = '0, wr_seen_d = '0;
    logic [15:0] log_a [64];
    bit          log_w [64];
    logic [15:0] log_d [64];
    int          log_c [64];
    int          log_pc [64];
    int          proto_err = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ready = 1'b0;
            wcnt = 0;
        end else if (bus_ready) begin
            bus_ready = 1'b0;
        end else if (bus_valid) begin
            if (wcnt < (hs_n % 3)) begin
                wcnt++;
            end else begin
                logic [15:0] full;
                logic [15:0] rd;
                wcnt = 0;
                hs_n++;
                hs_total++;
                bus_ready = 1'b1;
                rd = '0;
                if (txn_id != seen_id) begin
                    seen_id = txn_id;
                    busy_left = busy_cfg;
                    log_n = 0;
                end
                if (!bus_lock) proto_err++;
                if (bus_write && bus_addr == 12'h800) begin
                    page = bus_wdata[11:0];
                    page_fresh = 1;
                    page_cyc = cyc;
                end else begin
                    if (!page_fresh || bus_addr[1:0] != 2'b00 || bus_addr[11]) proto_err++;
                    if (page[11:7] != exp_dev) proto_err++;
                    page_fresh = 0;
                    full = {page[6:0], bus_addr[10:2]};
                    if (log_n < 64) begin
                        log_a[log_n] = full; log_w[log_n] = bus_write; log_d[log_n] = bus_wdata;
                        log_c[log_n] = cyc; log_pc[log_n] = page_cyc;
                    end
                    log_n++;
                    case (full)
                        16'h80a0: begin
                            if (bus_write) begin
                                if (bus_wdata[0]) begin
                                    if (bus_wdata[1]) begin wr_seen_a = areg; wr_seen_d = dreg; end
                                    else dreg = areg ^ 16'h5A3C;
                                    busy_left = busy_cfg;
                                end
                            end else begin
                                rd = {15'd0, busy_left != 0};
                                if (busy_left > 0) busy_left--;
                            end
                        end
                        16'h80a1: if (bus_write) areg = bus_wdata; else rd = areg;
                        16'h80a2: if (bus_write) dreg = bus_wdata; else rd = dreg;
                        default: proto_err++;
                    endcase
                end
                bus_rdata = rd;
            end
        end
    end

    task automatic run(input bit wr, input logic [15:0] addr, input logic [15:0] wd,
                       input logic [4:0] dev, input int bcfg, input bit inject);
        logic [15:0] e_a [64];
        bit          e_w [64];
        logic [15:0] e_d [64];
        int e_n, t, hs0, perr0;
        bit got, gerr, seq_ok, gap_ok, pgap_ok;
        logic [15:0] grd, exp_rd, wsa0;
        e_n = 0;
        if (bcfg >= PLIM) begin
            for (int k = 0; k < PLIM; k++) begin e_a[e_n] = 16'h80a0; e_w[e_n] = 0; e_d[e_n] = 0; e_n++; end
        end else begin
            for (int k = 0; k <= bcfg; k++) begin e_a[e_n] = 16'h80a0; e_w[e_n] = 0; e_d[e_n] = 0; e_n++; end
            e_a[e_n] = 16'h80a1; e_w[e_n] = 1; e_d[e_n] = addr; e_n++;
            if (wr) begin
                e_a[e_n] = 16'h80a2; e_w[e_n] = 1; e_d[e_n] = wd; e_n++;
                e_a[e_n] = 16'h80a0; e_w[e_n] = 1; e_d[e_n] = 16'h0003; e_n++;
            end else begin
                e_a[e_n] = 16'h80a0; e_w[e_n] = 1; e_d[e_n] = 16'h0001; e_n++;
                for (int k = 0; k <= bcfg; k++) begin e_a[e_n] = 16'h80a0; e_w[e_n] = 0; e_d[e_n] = 0; e_n++; end
                e_a[e_n] = 16'h80a2; e_w[e_n] = 0; e_d[e_n] = 0; e_n++;
            end
        end
        exp_rd = (bcfg >= PLIM || wr) ? 16'h0000 : (addr ^ 16'h5A3C);
        wsa0 = wr_seen_a;
        perr0 = proto_err;
        busy_cfg = bcfg;
        exp_dev = dev;
        txn_id++;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_dev = dev;
        @(negedge clk);
        req_valid = 1'b0;
        got = 0; grd = '0; gerr = 0;
        for (t = 0; t < 3000 && !got; t++) begin
            if (inject && t == 3) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h1234; req_wdata = 16'hBEEF;
            end else begin
                req_valid = 1'b0;
            end
            if (req_ack) begin got = 1; grd = req_rdata; gerr = req_err; end
            else @(negedge clk);
        end
        req_valid = 1'b0;
        check(got, "R8 ack arrives", {31'd0, got}, 32'd1);
        @(negedge clk);
        check(!req_ack, "R8 ack lasts one cycle", {31'd0, req_ack}, 32'd0);
        check(gerr == (bcfg >= PLIM), "R7 error flag", {31'd0, gerr}, {31'd0, bcfg >= PLIM});
        check(grd == exp_rd, "R5 R7 returned data", {16'd0, grd}, {16'd0, exp_rd});
        seq_ok = (log_n == e_n);
        for (int i = 0; i < e_n && i < log_n; i++)
            if (log_a[i] != e_a[i] || log_w[i] != e_w[i] || (e_w[i] && log_d[i] != e_d[i])) seq_ok = 0;
        check(seq_ok, wr ? "R3 R4 R7 write step order" : "R3 R5 R7 read step order", log_n, e_n);
        check(proto_err == perr0, "R1 R2 page/offset framing", proto_err - perr0, 0);
        gap_ok = 1; pgap_ok = 1;
        for (int i = 1; i < log_n && i < 64; i++) begin
            if (log_w[i-1] && (log_pc[i] - log_c[i-1]) < AGAP) gap_ok = 0;
            if (!log_w[i-1] && log_a[i-1] == 16'h80a0 && log_a[i] == 16'h80a0 && !log_w[i]
                && (log_pc[i] - log_c[i-1]) < PGAP) pgap_ok = 0;
        end
        check(gap_ok, "R6 step gap", {31'd0, gap_ok}, 32'd1);
        check(pgap_ok, "R3 poll spacing", {31'd0, pgap_ok}, 32'd1);
        if (wr && bcfg < PLIM)
            check(wr_seen_a == addr && wr_seen_d == wd, "R4 written pair",
                  {wr_seen_a, wr_seen_d}, {addr, wd});
        else
            check(wr_seen_a == wsa0, "R5 R7 no write started", {16'd0, wr_seen_a}, {16'd0, wsa0});
        if (inject) begin
            hs0 = hs_total;
            for (int k = 0; k < 60; k++) begin
                @(negedge clk);
                if (req_ack) n_fail += 0;
                check(!req_ack, "R9 no second ack", {31'd0, req_ack}, 32'd0);
                if (req_ack) break;
            end
            check(hs_total == hs0, "R9 no extra bus access", hs_total, hs0);
        end
    endtask

    initial begin : watchdog
        wait (cyc >= 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] addrs [6];
        logic [4:0]  devs [3];
        addrs[0] = 16'h0000; addrs[1] = 16'h01ff; addrs[2] = 16'h0200;
        addrs[3] = 16'h2002; addrs[4] = 16'hffff; addrs[5] = 16'h80a5;
        devs[0] = 5'd0; devs[1] = 5'd31; devs[2] = 5'd5;
        repeat (3) begin
            @(negedge clk);
            // R10
            check(!bus_valid && !bus_lock && !req_ack, "R10 reset outputs quiet",
                  {29'd0, bus_valid, bus_lock, req_ack}, 32'd0);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int a = 0; a < 6; a++)
            for (int d = 0; d < 3; d++)
                for (int b = 0; b < 3; b++)
                    for (int w = 0; w < 2; w++)
                        run(w[0], addrs[a], addrs[a] + 16'hC3A5 + 16'(d * 7), devs[d], b, 1'b0);
        run(1'b0, 16'h4321, 16'h0000, 5'd9, 10, 1'b0);
        run(1'b1, 16'h1357, 16'hA5A5, 5'd17, 10, 1'b0);
        run(1'b0, 16'h0abc, 16'h0000, 5'd3, 1, 1'b1);
        run(1'b1, 16'h7e01, 16'h1111, 5'd30, 0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule